// File: doc/BRIEF.md
# Ping-Pong Dual-Port Access Arbiter

This block shares one interface between two drive ports. Each port asks for the interface by pulling its active-low request pin low. At most one port holds the grant at any moment. A granted port keeps the grant for as long as its request stays low; it is never preempted. When both ports are waiting at the same time, the port that was not served most recently wins.

A microcontroller controls the block through a small register port and one interrupt line. The block has two modes:
- **Automatic mode:** the arbiter issues the grants. It latches data-received and output-requested events from the granted port as interrupt sources, each with its own mask bit. Software clears a source by writing 1 to it.
- **Manual mode:** the arbiter and the event logic are bypassed. Software writes the grant pins directly and reads the synchronized request pins.

The whole interface is live only while the enable input is high.

The arbiter is a state machine with four states:
- `ST_IDLE`: nobody owns the interface.
- `ST_OWN0`: port 0 owns the interface.
- `ST_OWN1`: port 1 owns the interface.
- `ST_RELEASE`: a one-cycle gap after an owner lets go.

Its transitions are:
- **IDLE→OWN0/OWN1 (grant):** a single request, or a tie resolved by the last-served flag.
- **IDLE→IDLE (wait):** there is no request.
- **OWNx→OWNx (hold):** the owner's request is still asserted.
- **OWNx→RELEASE (release):** the owner's request is seen deasserted.
- **RELEASE→OWN0/OWN1 (hand-over):** the same choice as from IDLE.
- **RELEASE→IDLE (drain):** no request is pending.
- **any→IDLE (bypass):** the block is disabled or in manual mode.

Register map. The address is 2 bits and the data is 4 bits. Reads are combinational.

| Address | Name | Access | Contents |
|---|---|---|---|
| 0 | Event status | Write 1 to clear | bit0 = port 0 data received, bit1 = port 0 output requested, bit2 = port 1 data received, bit3 = port 1 output requested |
| 1 | Interrupt mask | Read/write | Same bit layout as address 0 |
| 2 | Manual control | Read/write | bits[1:0] drive grant_o in manual mode |
| 3 | Request readback | Read only | bits[1:0] = synchronized active-high requests; bits[3:2] read 0 |

Top module: `pingpong_port_arbiter`

## Requirements
- R1: After reset, grant_o and irq_o are 0, and addresses 0, 1 and 2 read 0.
- R2: In automatic mode, at most one grant bit is high. A lone request that goes low between edges is granted on the third rising edge after it goes low: two edges of synchronization, then one edge of the state register. grant_o bit p belongs to port p.
- R3: An owner keeps its grant for as long as its request stays low, whatever the other port does.
- R4: An owner's grant drops on the third rising edge after its request pin rises. For that one cycle no port is granted. A waiting port is granted on the following edge.
- R5: When both synchronized requests are present while no port is granted, the port that did not win the last grant is granted. After reset, port 0 wins such a tie.
- R6: In automatic mode, an event input that is high at an edge sets its status bit at that edge, but only for the currently granted port. The bit layout is the one given for address 0.
- R7: Writing 1 to a status bit at address 0 clears it. If an event sets the same bit in the same cycle, the set wins.
- R8: irq_o is the OR of status bits ANDed with the mask bits at address 1, and is active only in automatic mode.
- R9: In manual mode, grant_o equals bits[1:0] of address 2. Events set no status bits, and irq_o is 0.
- R10: Address 3 reports the requests as active-high in bits[1:0], with the same two-edge synchronizer delay, in either mode.
- R11: While enable_i is low, grant_o and irq_o are 0, the status bits clear, and the arbiter returns to `ST_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Interface enable (mode select) |
| auto_mode_i | input | 1 | 1 = automatic arbitration, 0 = manual pin control |
| req_n_i | input | 2 | Active-low access request, one per port |
| din_ready_i | input | 2 | Per-port data-received event |
| dout_req_i | input | 2 | Per-port output-data-requested event |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 4 | Register write data |
| reg_rdata_o | output | 4 | Register read data |
| grant_o | output | 2 | Per-port grant |
| irq_o | output | 1 | Interrupt to the microcontroller |

## Verification
A state register stuck in an owner state shows up at the ports as a grant that outlives its request. It becomes visible three edges after the pin rises, and it blocks the waiting port one edge later. A corrupted last-served flag gives the wrong winner on the very next simultaneous request. A wrong status bit shows up at once on an address-0 read or on irq_o. The reference model is compared against grant_o, irq_o and the read data on every cycle, so any such fault is reported in the cycle it first reaches a port.

// File: rtl/arb_pkg.sv
package arb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_OWN0    = 2'd1,
        ST_OWN1    = 2'd2,
        ST_RELEASE = 2'd3
    } arb_state_t;

    localparam int NUM_PORTS = 2;
    localparam int REG_AW    = 2;
    localparam int REG_DW    = 2 * NUM_PORTS;

    localparam logic [REG_AW-1:0] ADDR_STATUS = 2'd0;
    localparam logic [REG_AW-1:0] ADDR_MASK   = 2'd1;
    localparam logic [REG_AW-1:0] ADDR_MANUAL = 2'd2;
    localparam logic [REG_AW-1:0] ADDR_PINS   = 2'd3;
endpackage

// File: rtl/arb_req_sync.sv
// Per-port synchronizer: active-low pin in, active-high request out.
// STAGES must be at least 2.
module arb_req_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] req_n_i,
    output logic [WIDTH-1:0] req_o
);
    for (genvar p = 0; p < WIDTH; p++) begin : g_port
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], ~req_n_i[p]};
        end
        assign req_o[p] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/arb_pingpong_fsm.sv
module arb_pingpong_fsm
    import arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic [1:0] req_i,
    output logic [1:0] grant_o
);
    arb_state_t state_q, state_d;
    logic       last_q;   // port that won the most recent grant

    // Choice made from IDLE or RELEASE.
    function automatic arb_state_t pick(input logic [1:0] r, input logic last);
        if (r == 2'b11)  return last ? ST_OWN0 : ST_OWN1;
        else if (r[0])   return ST_OWN0;
        else if (r[1])   return ST_OWN1;
        else             return ST_IDLE;
    endfunction

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    state_d = pick(req_i, last_q);
            ST_OWN0:    state_d = req_i[0] ? ST_OWN0 : ST_RELEASE;
            ST_OWN1:    state_d = req_i[1] ? ST_OWN1 : ST_RELEASE;
            ST_RELEASE: state_d = pick(req_i, last_q);
        endcase
        if (!run_i) state_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            last_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            if (state_d == ST_OWN0)      last_q <= 1'b0;
            else if (state_d == ST_OWN1) last_q <= 1'b1;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_OWN0: grant_o = 2'b01;
            ST_OWN1: grant_o = 2'b10;
            default: grant_o = 2'b00;
        endcase
    end

    assert_one_owner_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    assert_hold_owner_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && grant_o != 2'b00 && (grant_o & req_i) == grant_o) |=> (grant_o == $past(grant_o)));

    assert_release_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o != 2'b00 && (grant_o & req_i) == 2'b00) |=> (grant_o == 2'b00));

    assert_tie_to_port0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && grant_o == 2'b00 && req_i == 2'b11 && last_q) |=> (grant_o == 2'b01));

    assert_tie_to_port1_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && grant_o == 2'b00 && req_i == 2'b11 && !last_q) |=> (grant_o == 2'b10));

    assert_bypass_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (grant_o == 2'b00));
endmodule

// File: rtl/arb_event_bank.sv
module arb_event_bank #(
    parameter int NP = 2,
    localparam int NB = 2 * NP
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          auto_i,
    input  logic [NP-1:0] grant_i,
    input  logic [NP-1:0] din_i,
    input  logic [NP-1:0] dout_i,
    input  logic [NB-1:0] clr_i,
    input  logic          mask_we_i,
    input  logic [NB-1:0] mask_d_i,
    output logic [NB-1:0] flags_o,
    output logic [NB-1:0] mask_o,
    output logic          irq_o
);
    logic [NB-1:0] raw_v, set_v, flags_q, mask_q;

    for (genvar p = 0; p < NP; p++) begin : g_src
        assign raw_v[2*p]   = din_i[p]  & grant_i[p];
        assign raw_v[2*p+1] = dout_i[p] & grant_i[p];
    end

    assign set_v = (en_i && auto_i) ? raw_v : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     flags_q <= '0;
        else if (!en_i) flags_q <= '0;
        else            flags_q <= (flags_q & ~clr_i) | set_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         mask_q <= '0;
        else if (mask_we_i) mask_q <= mask_d_i;
    end

    assign flags_o = flags_q;
    assign mask_o  = mask_q;
    assign irq_o   = en_i & auto_i & (|(flags_q & mask_q));

    assert_set_beats_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && (set_v & clr_i) != '0) |=> ((flags_q & $past(set_v & clr_i)) == $past(set_v & clr_i)));

    assert_manual_no_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !auto_i && clr_i == '0) |=> $stable(flags_q));

    assert_disable_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (flags_q == '0));
endmodule

// File: rtl/pingpong_port_arbiter.sv
module pingpong_port_arbiter
    import arb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              auto_mode_i,
    input  logic [1:0]        req_n_i,
    input  logic [1:0]        din_ready_i,
    input  logic [1:0]        dout_req_i,
    input  logic              reg_we_i,
    input  logic [REG_AW-1:0] reg_addr_i,
    input  logic [REG_DW-1:0] reg_wdata_i,
    output logic [REG_DW-1:0] reg_rdata_o,
    output logic [1:0]        grant_o,
    output logic              irq_o
);
    logic [1:0]        req_s, fsm_grant;
    logic [REG_DW-1:0] flags, mask, manual_q, clr_v;
    logic              run;

    assign run = enable_i & auto_mode_i;

    arb_req_sync #(.WIDTH(NUM_PORTS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .req_n_i(req_n_i), .req_o(req_s)
    );

    arb_pingpong_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .run_i(run), .req_i(req_s), .grant_o(fsm_grant)
    );

    assign clr_v = (reg_we_i && reg_addr_i == ADDR_STATUS) ? reg_wdata_i : '0;

    arb_event_bank #(.NP(NUM_PORTS)) u_events (
        .clk(clk), .rst_n(rst_n), .en_i(enable_i), .auto_i(auto_mode_i),
        .grant_i(grant_o), .din_i(din_ready_i), .dout_i(dout_req_i),
        .clr_i(clr_v), .mask_we_i(reg_we_i && reg_addr_i == ADDR_MASK),
        .mask_d_i(reg_wdata_i), .flags_o(flags), .mask_o(mask), .irq_o(irq_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                    manual_q <= '0;
        else if (reg_we_i && reg_addr_i == ADDR_MANUAL) manual_q <= reg_wdata_i;
    end

    always_comb begin
        if (!enable_i)        grant_o = 2'b00;
        else if (auto_mode_i) grant_o = fsm_grant;
        else                  grant_o = manual_q[1:0];
    end

    always_comb begin
        unique case (reg_addr_i)
            ADDR_STATUS: reg_rdata_o = flags;
            ADDR_MASK:   reg_rdata_o = mask;
            ADDR_MANUAL: reg_rdata_o = manual_q;
            ADDR_PINS:   reg_rdata_o = {2'b00, req_s};
        endcase
    end

    assert_pins_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_n_i == 2'b11) |=> ##1 (req_s == 2'b00));
endmodule

// File: tb/pingpong_port_arbiter_tb.sv
`timescale 1ns/1ps
module pingpong_port_arbiter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable_i = 1'b0, auto_mode_i = 1'b0;
    logic [1:0] req_n_i = 2'b11, din_ready_i = 2'b00, dout_req_i = 2'b00;
    logic       reg_we_i = 1'b0;
    logic [1:0] reg_addr_i = 2'd0;
    logic [3:0] reg_wdata_i = 4'd0;
    logic [3:0] reg_rdata_o;
    logic [1:0] grant_o;
    logic       irq_o;

    int    checks = 0, errors = 0;
    string cur_tag = "R1";

    always #2.5 clk = ~clk;

    pingpong_port_arbiter dut_i (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .auto_mode_i(auto_mode_i),
        .req_n_i(req_n_i), .din_ready_i(din_ready_i), .dout_req_i(dout_req_i),
        .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .grant_o(grant_o), .irq_o(irq_o)
    );

    // Behavioural reference model.
    int       m_owner = -1;
    bit       m_last  = 1'b1;
    bit [1:0] m_s1 = 0, m_s2 = 0;
    bit [3:0] m_flags = 0, m_mask = 0, m_man = 0;

    function automatic bit [1:0] exp_grant();
        if (!enable_i)   return 2'b00;
        if (!auto_mode_i) return m_man[1:0];
        if (m_owner == 0) return 2'b01;
        if (m_owner == 1) return 2'b10;
        return 2'b00;
    endfunction

    function automatic bit exp_irq();
        return enable_i && auto_mode_i && ((m_flags & m_mask) != 0);
    endfunction

    function automatic bit [3:0] exp_rdata();
        case (reg_addr_i)
            2'd0:    return m_flags;
            2'd1:    return m_mask;
            2'd2:    return m_man;
            default: return {2'b00, m_s2};
        endcase
    endfunction

    task automatic model_step();
        bit [1:0] g;
        bit [3:0] setv, clrv;
        g    = exp_grant();
        setv = 0;
        if (enable_i && auto_mode_i)
            setv = {dout_req_i[1] & g[1], din_ready_i[1] & g[1], dout_req_i[0] & g[0], din_ready_i[0] & g[0]};
        clrv = (reg_we_i && reg_addr_i == 2'd0) ? reg_wdata_i : 4'd0;
        if (!enable_i) m_flags = 0;
        else           m_flags = (m_flags & ~clrv) | setv;
        if (reg_we_i && reg_addr_i == 2'd1) m_mask = reg_wdata_i;
        if (reg_we_i && reg_addr_i == 2'd2) m_man  = reg_wdata_i;
        if (!(enable_i && auto_mode_i)) m_owner = -1;
        else if (m_owner >= 0) begin
            if (!m_s2[m_owner]) m_owner = -1;
        end else begin
            if (m_s2 == 2'b11)  m_owner = m_last ? 0 : 1;
            else if (m_s2[0])   m_owner = 0;
            else if (m_s2[1])   m_owner = 1;
            if (m_owner >= 0)   m_last = (m_owner == 1);
        end
        m_s2 = m_s1;
        m_s1 = ~req_n_i;
    endtask

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk({cur_tag, " grant"}, {2'b00, grant_o}, {2'b00, exp_grant()});
        chk({cur_tag, " irq"}, {3'b000, irq_o}, {3'b000, exp_irq()});
        chk({cur_tag, " rdata"}, reg_rdata_o, exp_rdata());
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1 model_step();
            @(negedge clk);
            compare_all();
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [3:0] d);
        reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        tick();
        reg_we_i = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a);
        reg_addr_i = a;
        #0.1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        cur_tag = "R1";
        peek(2'd0); chk("R1 status", reg_rdata_o, 4'h0);
        peek(2'd1); chk("R1 mask", reg_rdata_o, 4'h0);
        peek(2'd2); chk("R1 manual", reg_rdata_o, 4'h0);
        chk("R1 grant", {2'b00, grant_o}, 4'h0);
        chk("R1 irq", {3'b000, irq_o}, 4'h0);
        enable_i = 1'b1; auto_mode_i = 1'b1; peek(2'd0);
        tick(2);
        // R2 lone request latency
        cur_tag = "R2";
        req_n_i = 2'b10;
        tick(2); chk("R2 not yet granted", {2'b00, grant_o}, 4'h0);
        tick();  chk("R2 port0 granted", {2'b00, grant_o}, 4'h1);
        // R3 hold against competing request
        cur_tag = "R3";
        req_n_i = 2'b00;
        tick(8); chk("R3 owner held", {2'b00, grant_o}, 4'h1);
        // R4 release with one-cycle gap
        cur_tag = "R4";
        req_n_i = 2'b01;
        tick(2); chk("R4 still owned", {2'b00, grant_o}, 4'h1);
        tick();  chk("R4 gap cycle", {2'b00, grant_o}, 4'h0);
        tick();  chk("R4 hand-over to port1", {2'b00, grant_o}, 4'h2);
        // R6 event latching for owner only
        cur_tag = "R6";
        din_ready_i = 2'b11;
        tick();
        din_ready_i = 2'b00;
        peek(2'd0); chk("R6 only port1 data bit", reg_rdata_o, 4'h4);
        // R8 interrupt masking
        cur_tag = "R8";
        chk("R8 masked irq", {3'b000, irq_o}, 4'h0);
        reg_write(2'd1, 4'h4);
        chk("R8 unmasked irq", {3'b000, irq_o}, 4'h1);
        // R7 clear-on-one, set wins
        cur_tag = "R7";
        dout_req_i = 2'b10;
        reg_write(2'd0, 4'hC);
        dout_req_i = 2'b00;
        peek(2'd0); chk("R7 clear and set-wins", reg_rdata_o, 4'h8);
        chk("R7 irq after clear", {3'b000, irq_o}, 4'h0);
        // R5 ping-pong tie breaking
        cur_tag = "R5";
        req_n_i = 2'b11;
        tick(4); chk("R5 idle", {2'b00, grant_o}, 4'h0);
        req_n_i = 2'b00;
        tick(3); chk("R5 tie to port0 after port1", {2'b00, grant_o}, 4'h1);
        req_n_i = 2'b11;
        tick(4);
        req_n_i = 2'b00;
        tick(3); chk("R5 tie to port1 after port0", {2'b00, grant_o}, 4'h2);
        // R9 manual mode
        cur_tag = "R9";
        req_n_i = 2'b11; auto_mode_i = 1'b0;
        tick();
        reg_write(2'd2, 4'h3);
        chk("R9 manual grants", {2'b00, grant_o}, 4'h3);
        din_ready_i = 2'b11; dout_req_i = 2'b11;
        tick(2);
        din_ready_i = 2'b00; dout_req_i = 2'b00;
        reg_write(2'd1, 4'hF);
        peek(2'd0); chk("R9 no latching", reg_rdata_o, 4'h8);
        chk("R9 irq off", {3'b000, irq_o}, 4'h0);
        // R10 request readback
        cur_tag = "R10";
        peek(2'd3);
        req_n_i = 2'b01;
        tick(); chk("R10 before sync", reg_rdata_o, 4'h0);
        tick(); chk("R10 after sync", reg_rdata_o, 4'h2);
        // R11 disable
        cur_tag = "R11";
        enable_i = 1'b0; auto_mode_i = 1'b1; req_n_i = 2'b00;
        tick(); peek(2'd0);
        chk("R11 status cleared", reg_rdata_o, 4'h0);
        tick(5);
        chk("R11 grant off", {2'b00, grant_o}, 4'h0);
        chk("R11 irq off", {3'b000, irq_o}, 4'h0);
        enable_i = 1'b1; req_n_i = 2'b11;
        tick(3);
        cur_tag = "R2";
        req_n_i = 2'b01;
        tick(3); chk("R2 port1 alone after re-enable", {2'b00, grant_o}, 4'h2);
        tick(2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R1 watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule